// File: doc/BRIEF.md
# Minimal 8-bit Accumulator Processor Core

This block is a small multi-cycle processor with an 8-bit data path and a unified 16-byte memory that holds both the program and its data. Two operand registers (A and B) feed an adder/subtractor whose result lands in an accumulator. A 4-bit program counter walks the memory. Every instruction is one byte: a 4-bit operation code over a 4-bit direct memory address.

The core executes twelve operations: two register loads, add and subtract, accumulator write-back, an unconditional jump, three compare-and-branch operations that test A against B directly (no flag register), two output-bus dumps, and a halt. Results leave the core only through an 8-bit output bus qualified by a one-cycle valid strobe. A halted flag shows that execution has stopped.

A preload port writes the memory, normally while reset is held, so that a program and its data can be placed before the core starts. Memory contents survive reset.

Top module: `cpu8_core`

## Requirements
- R1: An instruction byte carries the operation code in bits 7:4 and a direct memory address in bits 3:0.
- R2: Code 1000 loads the memory byte at the address into A; code 0100 loads it into B.
- R3: Code 0010 puts A+B in the accumulator and code 0001 puts A-B there, both modulo 256.
- R4: Code 1010 writes the accumulator to memory at the address, and a later fetch or load from that address returns the new value.
- R5: Code 1001 sets the program counter to the address.
- R6: Codes 0101, 0111 and 0011 branch to the address when A==B, A>B or A<B (unsigned) respectively; otherwise execution falls through to the next byte.
- R7: Code 1011 puts A on the output bus and code 1101 puts B on it, each for exactly one cycle with the valid strobe high; with the strobe low the bus reads zero.
- R8: Code 1111 stops the core: the halted flag rises and stays high, the program counter and registers hold, and no strobe appears until reset.
- R9: After reset release each instruction takes three cycles (fetch, decode, execute), loads take a fourth; the halted flag is seen high after the last cycle of the halt instruction. The counter steps by one per fetch and wraps from 15 to 0.
- R10: Codes 0000, 0110, 1100 and 1110 change no register and produce no output.
- R11: Synchronous reset clears A, B, the accumulator and the program counter and lowers the halted flag and strobe; memory is not cleared, and the preload port writes pre_data to location pre_addr on any clock edge with pre_we high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pre_we | input | 1 | Preload write enable |
| pre_addr | input | 4 | Preload location |
| pre_data | input | 8 | Preload byte |
| out_data | output | 8 | Output bus, zero when not valid |
| out_valid | output | 1 | One-cycle strobe for out_data |
| halted | output | 1 | High once a halt has executed |

## Verification
The hardest state to reach from the ports is a program counter that wraps past location 15 into code it has itself rewritten: the bench jumps near the top of memory, builds an opcode in the accumulator from two data bytes, stores it over location 0 and runs through the wrap, so the only output comes from the self-written instruction. A second run after reset, with no preload, then shows both retained memory and cleared registers. Arithmetic and all three branch outcomes are swept over a 16 by 16 grid of operand values including 0 and 255, with expected bus streams and cycle counts worked out in the bench.

// File: rtl/cpu8_pkg.sv
package cpu8_pkg;
  localparam int unsigned DW = 8;
  localparam int unsigned AW = 4;
  localparam int unsigned OPW = DW - AW;

  localparam logic [OPW-1:0] OPC_LOADA = 4'b1000;
  localparam logic [OPW-1:0] OPC_LOADB = 4'b0100;
  localparam logic [OPW-1:0] OPC_SUM   = 4'b0010;
  localparam logic [OPW-1:0] OPC_DIFF  = 4'b0001;
  localparam logic [OPW-1:0] OPC_GOTO  = 4'b1001;
  localparam logic [OPW-1:0] OPC_STOP  = 4'b1111;
  localparam logic [OPW-1:0] OPC_STORE = 4'b1010;
  localparam logic [OPW-1:0] OPC_SHOWA = 4'b1011;
  localparam logic [OPW-1:0] OPC_SHOWB = 4'b1101;
  localparam logic [OPW-1:0] OPC_BEQ   = 4'b0101;
  localparam logic [OPW-1:0] OPC_BGT   = 4'b0111;
  localparam logic [OPW-1:0] OPC_BLT   = 4'b0011;

  typedef enum logic [2:0] {
    ST_FETCH,
    ST_DECODE,
    ST_EXEC,
    ST_LOAD,
    ST_HALT
  } state_t;

  function automatic logic [DW-1:0] alu_sum(input logic [DW-1:0] x, input logic [DW-1:0] y);
    return x + y;
  endfunction

  function automatic logic [DW-1:0] alu_diff(input logic [DW-1:0] x, input logic [DW-1:0] y);
    return x - y;
  endfunction

  function automatic logic branch_taken(input logic [OPW-1:0] op,
                                        input logic [DW-1:0] x, input logic [DW-1:0] y);
    case (op)
      OPC_BEQ: return x == y;
      OPC_BGT: return x > y;
      OPC_BLT: return x < y;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/cpu8_mem.sv
module cpu8_mem
  import cpu8_pkg::*;
#(
  parameter int unsigned WIDTH = DW,
  parameter int unsigned ABITS = AW
) (
  input  logic             clk,
  input  logic [ABITS-1:0] addr,
  input  logic             core_we,
  input  logic [WIDTH-1:0] core_wdata,
  input  logic             pre_we,
  input  logic [ABITS-1:0] pre_addr,
  input  logic [WIDTH-1:0] pre_data,
  output logic [WIDTH-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << ABITS;

  logic [WIDTH-1:0] cells [DEPTH];

  // preload port wins over a core write in the same cycle
  always_ff @(posedge clk) begin
    if (pre_we) begin
      cells[pre_addr] <= pre_data;
    end else if (core_we) begin
      cells[addr] <= core_wdata;
    end
    rdata <= cells[addr];
  end
endmodule

// File: rtl/cpu8_ctrl.sv
module cpu8_ctrl
  import cpu8_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic [OPW-1:0] ir_op,
  input  logic [DW-1:0]  reg_a,
  input  logic [DW-1:0]  reg_b,
  output logic           addr_sel_pc,
  output logic           ir_load,
  output logic           pc_inc,
  output logic           pc_jump,
  output logic           mem_we,
  output logic           load_a,
  output logic           load_b,
  output logic           acc_sum,
  output logic           acc_diff,
  output logic           show_a,
  output logic           show_b,
  output logic           halted
);
  state_t state, state_nx;

  logic in_exec, in_load;
  logic is_loada, is_loadb, is_mem_load, is_goto, is_stop, is_cond, cond_ok;

  assign in_exec     = (state == ST_EXEC);
  assign in_load     = (state == ST_LOAD);
  assign is_loada    = (ir_op == OPC_LOADA);
  assign is_loadb    = (ir_op == OPC_LOADB);
  assign is_mem_load = is_loada | is_loadb;
  assign is_goto     = (ir_op == OPC_GOTO);
  assign is_stop     = (ir_op == OPC_STOP);
  assign is_cond     = (ir_op == OPC_BEQ) | (ir_op == OPC_BGT) | (ir_op == OPC_BLT);
  assign cond_ok     = branch_taken(ir_op, reg_a, reg_b);

  always_comb begin
    state_nx = state;
    case (state)
      ST_FETCH:  state_nx = ST_DECODE;
      ST_DECODE: state_nx = ST_EXEC;
      ST_EXEC: begin
        if (is_stop)          state_nx = ST_HALT;
        else if (is_mem_load) state_nx = ST_LOAD;
        else                  state_nx = ST_FETCH;
      end
      ST_LOAD:   state_nx = ST_FETCH;
      ST_HALT:   state_nx = ST_HALT;
      default:   state_nx = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_FETCH;
    else     state <= state_nx;
  end

  assign addr_sel_pc = (state == ST_FETCH);
  assign ir_load     = (state == ST_DECODE);
  assign pc_inc      = (state == ST_DECODE);
  assign pc_jump     = in_exec & (is_goto | (is_cond & cond_ok));
  assign mem_we      = in_exec & (ir_op == OPC_STORE);
  assign load_a      = in_load & is_loada;
  assign load_b      = in_load & is_loadb;
  assign acc_sum     = in_exec & (ir_op == OPC_SUM);
  assign acc_diff    = in_exec & (ir_op == OPC_DIFF);
  assign show_a      = in_exec & (ir_op == OPC_SHOWA);
  assign show_b      = in_exec & (ir_op == OPC_SHOWB);
  assign halted      = (state == ST_HALT);

  // R8: once stopped, the core stays stopped until reset
  a_r8_halt_sticky: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  // R6: a jump only happens in the cycle right after decode
  a_r6_jump_after_decode: assert property (@(posedge clk) disable iff (rst)
    pc_jump |-> $past(ir_load));

  // R9: the extra load cycle is always followed by a fetch
  a_r9_load_then_fetch: assert property (@(posedge clk) disable iff (rst)
    in_load |=> addr_sel_pc);
endmodule

// File: rtl/cpu8_datapath.sv
module cpu8_datapath
  import cpu8_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] rdata,
  input  logic          ir_load,
  input  logic          pc_inc,
  input  logic          pc_jump,
  input  logic          load_a,
  input  logic          load_b,
  input  logic          acc_sum,
  input  logic          acc_diff,
  input  logic          show_a,
  input  logic          show_b,
  input  logic          halted,
  output logic [AW-1:0] pc,
  output logic [DW-1:0] ir,
  output logic [DW-1:0] reg_a,
  output logic [DW-1:0] reg_b,
  output logic [DW-1:0] acc,
  output logic [DW-1:0] out_data,
  output logic          out_valid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pc    <= '0;
      ir    <= '0;
      reg_a <= '0;
      reg_b <= '0;
      acc   <= '0;
    end else begin
      if (ir_load) ir <= rdata;
      if (pc_jump)     pc <= ir[AW-1:0];
      else if (pc_inc) pc <= pc + 1'b1;
      if (load_a) reg_a <= rdata;
      if (load_b) reg_b <= rdata;
      if (acc_sum)       acc <= alu_sum(reg_a, reg_b);
      else if (acc_diff) acc <= alu_diff(reg_a, reg_b);
    end
  end

  assign out_valid = show_a | show_b;
  assign out_data  = show_a ? reg_a : (show_b ? reg_b : '0);

  // R9: decode advances the counter by one, wrapping at the top
  a_r9_pc_step: assert property (@(posedge clk) disable iff (rst)
    ir_load |=> pc == AW'($past(pc) + 1'b1));

  // R8: nothing moves while stopped
  a_r8_frozen: assert property (@(posedge clk) disable iff (rst)
    halted |=> ($stable(pc) && $stable(reg_a) && $stable(reg_b) && $stable(acc)));

  // R7: no strobe while stopped, and the bus is quiet without a strobe
  a_r7_no_strobe_halted: assert property (@(posedge clk) disable iff (rst)
    halted |-> !out_valid);
  a_r7_quiet_bus: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> out_data == '0);
endmodule

// File: rtl/cpu8_core.sv
module cpu8_core
  import cpu8_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          pre_we,
  input  logic [3:0]    pre_addr,
  input  logic [7:0]    pre_data,
  output logic [7:0]    out_data,
  output logic          out_valid,
  output logic          halted
);
  logic          addr_sel_pc, ir_load, pc_inc, pc_jump, mem_we;
  logic          load_a, load_b, acc_sum, acc_diff, show_a, show_b;
  logic [AW-1:0] pc, mem_addr;
  logic [DW-1:0] ir, reg_a, reg_b, acc, rdata;

  // R1: operand address comes from the low field of the instruction byte
  assign mem_addr = addr_sel_pc ? pc : ir[AW-1:0];

  cpu8_mem #(.WIDTH(DW), .ABITS(AW)) u_mem (
    .clk        (clk),
    .addr       (mem_addr),
    .core_we    (mem_we),
    .core_wdata (acc),
    .pre_we     (pre_we),
    .pre_addr   (pre_addr),
    .pre_data   (pre_data),
    .rdata      (rdata)
  );

  cpu8_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .ir_op       (ir[DW-1:AW]),
    .reg_a       (reg_a),
    .reg_b       (reg_b),
    .addr_sel_pc (addr_sel_pc),
    .ir_load     (ir_load),
    .pc_inc      (pc_inc),
    .pc_jump     (pc_jump),
    .mem_we      (mem_we),
    .load_a      (load_a),
    .load_b      (load_b),
    .acc_sum     (acc_sum),
    .acc_diff    (acc_diff),
    .show_a      (show_a),
    .show_b      (show_b),
    .halted      (halted)
  );

  cpu8_datapath u_dp (
    .clk       (clk),
    .rst       (rst),
    .rdata     (rdata),
    .ir_load   (ir_load),
    .pc_inc    (pc_inc),
    .pc_jump   (pc_jump),
    .load_a    (load_a),
    .load_b    (load_b),
    .acc_sum   (acc_sum),
    .acc_diff  (acc_diff),
    .show_a    (show_a),
    .show_b    (show_b),
    .halted    (halted),
    .pc        (pc),
    .ir        (ir),
    .reg_a     (reg_a),
    .reg_b     (reg_b),
    .acc       (acc),
    .out_data  (out_data),
    .out_valid (out_valid)
  );

  // R4: memory is written only by a store, never during fetch
  a_r4_store_not_fetch: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> !addr_sel_pc);
endmodule

// File: tb/cpu8_core_tb.sv
module cpu8_core_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pre_we = 1'b0;
  logic [3:0] pre_addr = '0;
  logic [7:0] pre_data = '0;
  logic [7:0] out_data;
  logic       out_valid;
  logic       halted;

  always #4 clk = ~clk;

  cpu8_core u_dut (
    .clk(clk), .rst(rst), .pre_we(pre_we), .pre_addr(pre_addr),
    .pre_data(pre_data), .out_data(out_data), .out_valid(out_valid), .halted(halted)
  );

  int vectors = 0;
  int miscompares = 0;
  int total_cycles = 0;

  logic [7:0] img [16];
  logic [7:0] obs [8];
  int         nobs;
  int         run_cycles;
  logic [7:0] expv [8];
  int         nexp;

  always @(posedge clk) begin
    total_cycles <= total_cycles + 1;
    if (total_cycles > 190000) begin
      miscompares = miscompares + 1;
      $display("FAIL watchdog: actual %0d cycles, expected under 190000", total_cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors = vectors + 1;
    if (!ok) begin
      miscompares = miscompares + 1;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Hold reset, optionally preload the image, release and run to halt.
  task automatic run(input bit preload, input bit chk_reset);
    @(negedge clk);
    rst = 1'b1;
    if (preload) begin
      for (int i = 0; i < 16; i++) begin
        pre_we = 1'b1; pre_addr = 4'(i); pre_data = img[i];
        @(negedge clk);
      end
      pre_we = 1'b0;
    end
    @(negedge clk);
    @(negedge clk);
    if (chk_reset) begin
      chk(out_valid == 1'b0, "R11 strobe in reset", int'(out_valid), 0);
      chk(halted == 1'b0, "R11 halted in reset", int'(halted), 0);
    end
    rst = 1'b0;
    nobs = 0;
    run_cycles = 0;
    for (int c = 0; c < 300; c++) begin
      @(negedge clk);
      run_cycles++;
      if (out_valid && nobs < 8) begin
        obs[nobs] = out_data;
        nobs++;
      end
      if (halted) break;
    end
  endtask

  task automatic compare_stream(input string req);
    chk(nobs == nexp, req, nobs, nexp);
    for (int i = 0; i < nexp && i < nobs; i++)
      chk(obs[i] == expv[i], req, int'(obs[i]), int'(expv[i]));
  endtask

  initial begin
    // arithmetic sweep: R1 R2 R3 R4 R7 R9
    for (int ia = 0; ia < 16; ia++) begin
      for (int ib = 0; ib < 16; ib++) begin
        int a, b;
        a = ia * 17; b = ib * 17;
        img = '{8'h8E, 8'h4F, 8'h20, 8'hAD, 8'h10, 8'hAC, 8'h8D, 8'hB0,
                8'h8C, 8'hB0, 8'hD0, 8'hF0, 8'h00, 8'h00, 8'(a), 8'(b)};
        run(1'b1, ia == 0 && ib == 0);
        nexp = 3;
        expv[0] = 8'((a + b) % 256);          // R3 sum, via R4 store and R2 reload
        expv[1] = 8'((a - b + 256) % 256);    // R3 difference
        expv[2] = 8'(b);                      // R7 B dump
        compare_stream("R3 arithmetic stream");
        chk(run_cycles == 40, "R9 arithmetic cycle count", run_cycles, 40);
        chk(halted == 1'b1, "R8 halted flag", int'(halted), 1);
      end
    end

    // compare sweep: R6 (BEQ 0101 -> 6, BGT 0111 -> 8, BLT 0011 -> 10)
    for (int ia = 0; ia < 16; ia++) begin
      for (int ib = 0; ib < 16; ib++) begin
        int a, b, ecyc;
        a = ia * 17; b = ib * 17;
        img = '{8'h8E, 8'h4F, 8'h56, 8'h78, 8'h3A, 8'hF0, 8'hB0, 8'hF0,
                8'hD0, 8'hF0, 8'hB0, 8'hD0, 8'hF0, 8'h00, 8'(a), 8'(b)};
        run(1'b1, 1'b0);
        if (a == b) begin
          nexp = 1; expv[0] = 8'(a); ecyc = 17;
        end else if (a > b) begin
          nexp = 1; expv[0] = 8'(b); ecyc = 20;
        end else begin
          nexp = 2; expv[0] = 8'(a); expv[1] = 8'(b); ecyc = 26;
        end
        compare_stream("R6 branch outcome");
        chk(run_cycles == ecyc, "R6 branch cycle count", run_cycles, ecyc);
      end
    end

    // R10: unused codes 0000 0110 1100 1110 between a load and a dump
    img = '{8'h8E, 8'h00, 8'h6F, 8'hC3, 8'hE5, 8'hB0, 8'hF0, 8'h00,
            8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h5A, 8'h00};
    run(1'b1, 1'b0);
    nexp = 1; expv[0] = 8'h5A;
    compare_stream("R10 no-op codes");
    chk(run_cycles == 22, "R10 no-op cycle count", run_cycles, 22);

    // R5 R9 R4: jump high, build 0xB0 in the accumulator, store to 0, wrap
    img = '{8'h9B, 8'hF0, 8'hC0, 8'hC0, 8'hC0, 8'hC0, 8'hC0, 8'hC0,
            8'hC0, 8'h60, 8'h50, 8'h8A, 8'h49, 8'h20, 8'hA0, 8'hE0};
    run(1'b1, 1'b0);
    nexp = 1; expv[0] = 8'h50;
    compare_stream("R9 wrap into self-written code");
    chk(run_cycles == 26, "R5 jump and wrap cycle count", run_cycles, 26);

    // R8: stays halted, silent
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (out_valid || !halted)
        chk(1'b0, "R8 frozen after halt", int'({halted, out_valid}), 2);
    end
    chk(halted == 1'b1, "R8 still halted", int'(halted), 1);

    // R11: reset again without preload; location 0 now holds 0xB0, A cleared
    run(1'b0, 1'b1);
    nexp = 1; expv[0] = 8'h00;
    compare_stream("R11 memory kept, registers cleared");
    chk(run_cycles == 6, "R11 rerun cycle count", run_cycles, 6);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule